// File: doc/BRIEF.md
# Card Host Interrupt Status and Mask Unit

This unit gathers the event flags of a removable-card host controller into a sticky status register, filters them through a mask register, and drives one combined, registered interrupt line. Event sources pulse single-cycle set strobes: card inserted, card removed, response received, response timeout, CRC error, transfer finished, receive data available, transmit data wanted, receive overflow and transmit underrun. Two more bits track the live level of the write-protect switch and of the command-busy indication. These bits are not latched.

A second, narrower status and mask pair serves the interrupt raised by an I/O-type card. Only its I/O interrupt bit can raise the line. Software reaches all four registers through a simple register port. Writes take effect on the next clock edge, and reads return data one cycle after the address is presented. A status bit is acknowledged by writing 0 to it. Writing 1 leaves the bit as it is, so software acknowledges a set of bits by writing their complement. An instance built for external card detection keeps both card-presence events masked at all times.

Top module: `card_irq_unit`

## Requirements
- R1: After reset every status event bit is 0, every bit of both mask registers is 1, and the interrupt output is 0.
- R2: A one-cycle set strobe on an event bit sets that status bit on the next edge, and the bit stays set until software clears it.
- R3: A write to a status register (main at address 0, I/O at address 2) clears each bit written 0 and leaves each bit written 1 unchanged. A write never sets a bit.
- R4: When a set strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A mask bit of 1 blocks its event. The interrupt output equals the OR of status AND interrupt-capable AND NOT mask, delayed by one register. The main mask is at address 1 and the I/O mask at address 3.
- R6: Only interrupt-capable bits can raise the interrupt. In the main register these are bits 0 to 9; bits 10 and 11 are levels, and bits 12 and up always read 0.
- R7: Status bit 10 follows the write-protect input and bit 11 follows the command-busy input. Writes have no effect on either bit.
- R8: I/O status bits are set by I/O event strobes. Only I/O bit 0 can raise the interrupt, and only while I/O mask bit 0 is 0.
- R9: With external card detection selected, main mask bits 0 (removed) and 1 (inserted) always read 1, whatever is written, so those events never raise the interrupt.
- R10: The interrupt stays high as long as any pending bit remains unmasked, and falls one cycle after the last one is cleared or masked.
- R11: Read data shows the register selected by the address on the previous edge. The I/O registers are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | STAT_W | One-cycle set strobes for the main status bits |
| wp_level | input | 1 | Write-protect switch level |
| busy_level | input | 1 | Command-busy level |
| io_evt_set | input | IO_W | One-cycle set strobes for the I/O status bits |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 I/O status, 3 I/O mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | STAT_W | Write data |
| reg_rdata | output | STAT_W | Registered read data |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds two instances side by side with a 32-bit main register and a 16-bit I/O register. One instance uses on-chip card detection and the other uses external detection, so the forced mask bits and the silenced card events can be compared against an instance where the same writes unmask them. With the default widths the bench can also reach the reserved upper bits, so it shows that they neither latch nor raise the line.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_IOSTAT = 2'd2,
    SEL_IOMASK = 2'd3
  } reg_sel_e;

  localparam int POS_CARD_GONE  = 0;
  localparam int POS_CARD_NEW   = 1;
  localparam int POS_RESP_OK    = 2;
  localparam int POS_RESP_TMO   = 3;
  localparam int POS_CRC_BAD    = 4;
  localparam int POS_XFER_DONE  = 5;
  localparam int POS_RX_AVAIL   = 6;
  localparam int POS_TX_WANT    = 7;
  localparam int POS_RX_OVF     = 8;
  localparam int POS_TX_UNF     = 9;
  localparam int POS_WP_LVL     = 10;
  localparam int POS_BUSY_LVL   = 11;
  localparam int POS_IO_INT     = 0;

  localparam int NUM_EVENTS     = 10;

endpackage

// File: rtl/card_irq_status_bank.sv
module card_irq_status_bank #(
  parameter int             W          = 32,
  parameter logic [W-1:0]   EVENT_BITS = '1,
  parameter logic [W-1:0]   LEVEL_BITS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] lvl_in,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] stat
);

  localparam logic HAS_LEVELS = (LEVEL_BITS != '0);

  logic [W-1:0] ev_q;
  logic [W-1:0] clr_vec;

  // A written 0 requests clearing; a written 1 leaves the bit alone.
  assign clr_vec = wr_en ? ~wr_data : '0;

  // Setting has priority over clearing in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
    end else begin
      ev_q <= EVENT_BITS & (evt_set | (ev_q & ~clr_vec));
    end
  end

  generate
    if (HAS_LEVELS) begin : g_lvl
      assign stat = ev_q | (lvl_in & LEVEL_BITS);
    end else begin : g_nolvl
      logic unused_lvl;
      assign unused_lvl = |lvl_in;
      assign stat = ev_q;
    end
  endgenerate

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (|(evt_set & EVENT_BITS)) |=> ((ev_q & $past(evt_set & EVENT_BITS)) == $past(evt_set & EVENT_BITS))); // R4

  AST_STICKY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((ev_q & $past(ev_q)) == $past(ev_q))); // R2

  AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_set == '0) |=> ((ev_q & ~$past(ev_q)) == '0)); // R3

endmodule

// File: rtl/card_irq_mask_reg.sv
module card_irq_mask_reg #(
  parameter int           W         = 32,
  parameter logic [W-1:0] FORCE_SET = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (wr_en) begin
      mask_q <= wr_data | FORCE_SET;
    end
  end

  assign mask = mask_q;

  AST_MASK_RESET: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == {W{1'b1}})); // R1

endmodule

// File: rtl/card_irq_merge.sv
module card_irq_merge #(
  parameter int            WA    = 32,
  parameter int            WB    = 16,
  parameter logic [WA-1:0] CAP_A = '1,
  parameter logic [WB-1:0] CAP_B = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WA-1:0] stat_a,
  input  logic [WA-1:0] mask_a,
  input  logic [WB-1:0] stat_b,
  input  logic [WB-1:0] mask_b,
  output logic          irq
);

  logic [WA-1:0] pend_a;
  logic [WB-1:0] pend_b;
  logic          irq_q;

  assign pend_a = stat_a & CAP_A & ~mask_a;
  assign pend_b = stat_b & CAP_B & ~mask_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= (|pend_a) | (|pend_b);
    end
  end

  assign irq = irq_q;

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((&mask_a) && (&mask_b)) |=> !irq_q); // R5

  AST_INCAPABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (((stat_a & CAP_A) == '0) && ((stat_b & CAP_B) == '0)) |=> !irq_q); // R6

endmodule

// File: rtl/card_irq_unit.sv
module card_irq_unit
  import card_irq_pkg::*;
#(
  parameter int STAT_W          = 32,
  parameter int IO_W            = 16,
  parameter bit EXT_CARD_DETECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              wp_level,
  input  logic              busy_level,
  input  logic [IO_W-1:0]   io_evt_set,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              irq
);

  localparam logic [STAT_W-1:0] ONE_W       = STAT_W'(1);
  localparam logic [STAT_W-1:0] EVENT_BITS  = (ONE_W << NUM_EVENTS) - ONE_W;
  localparam logic [STAT_W-1:0] LEVEL_BITS  = (ONE_W << POS_WP_LVL) | (ONE_W << POS_BUSY_LVL);
  localparam logic [STAT_W-1:0] IRQ_BITS    = EVENT_BITS;
  localparam logic [STAT_W-1:0] CARD_BITS   = (ONE_W << POS_CARD_GONE) | (ONE_W << POS_CARD_NEW);
  localparam logic [STAT_W-1:0] FORCE_MASK  = EXT_CARD_DETECT ? CARD_BITS : '0;
  localparam logic [IO_W-1:0]   IO_ONE      = IO_W'(1);
  localparam logic [IO_W-1:0]   IO_EVENTS   = '1;
  localparam logic [IO_W-1:0]   IO_IRQ_BITS = IO_ONE << POS_IO_INT;
  localparam int                PAD_W       = STAT_W - IO_W;

  reg_sel_e sel;
  logic     wr_stat, wr_mask, wr_iostat, wr_iomask;

  logic [STAT_W-1:0] lvl_vec;
  logic [STAT_W-1:0] stat_main, mask_main;
  logic [IO_W-1:0]   stat_io, mask_io;
  logic [STAT_W-1:0] rdata_q;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_stat   = reg_wr && (sel == SEL_STAT);
  assign wr_mask   = reg_wr && (sel == SEL_MASK);
  assign wr_iostat = reg_wr && (sel == SEL_IOSTAT);
  assign wr_iomask = reg_wr && (sel == SEL_IOMASK);

  always_comb begin
    lvl_vec               = '0;
    lvl_vec[POS_WP_LVL]   = wp_level;
    lvl_vec[POS_BUSY_LVL] = busy_level;
  end

  card_irq_status_bank #(
    .W          (STAT_W),
    .EVENT_BITS (EVENT_BITS),
    .LEVEL_BITS (LEVEL_BITS)
  ) u_main_stat (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_set),
    .lvl_in  (lvl_vec),
    .wr_en   (wr_stat),
    .wr_data (reg_wdata),
    .stat    (stat_main)
  );

  card_irq_mask_reg #(
    .W         (STAT_W),
    .FORCE_SET (FORCE_MASK)
  ) u_main_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_mask),
    .wr_data (reg_wdata),
    .mask    (mask_main)
  );

  card_irq_status_bank #(
    .W          (IO_W),
    .EVENT_BITS (IO_EVENTS),
    .LEVEL_BITS ('0)
  ) u_io_stat (
    .clk     (clk),
    .rst     (rst),
    .evt_set (io_evt_set),
    .lvl_in  ('0),
    .wr_en   (wr_iostat),
    .wr_data (reg_wdata[IO_W-1:0]),
    .stat    (stat_io)
  );

  card_irq_mask_reg #(
    .W         (IO_W),
    .FORCE_SET ('0)
  ) u_io_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_iomask),
    .wr_data (reg_wdata[IO_W-1:0]),
    .mask    (mask_io)
  );

  card_irq_merge #(
    .WA    (STAT_W),
    .WB    (IO_W),
    .CAP_A (IRQ_BITS),
    .CAP_B (IO_IRQ_BITS)
  ) u_merge (
    .clk    (clk),
    .rst    (rst),
    .stat_a (stat_main),
    .mask_a (mask_main),
    .stat_b (stat_io),
    .mask_b (mask_io),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (sel)
        SEL_STAT:   rdata_q <= stat_main;
        SEL_MASK:   rdata_q <= mask_main;
        SEL_IOSTAT: rdata_q <= {{PAD_W{1'b0}}, stat_io};
        SEL_IOMASK: rdata_q <= {{PAD_W{1'b0}}, mask_io};
      endcase
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: tb/card_irq_unit_test.sv
`timescale 1ns/1ps
module card_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_set = '0;
  logic        wp_level = 1'b0;
  logic        busy_level = 1'b0;
  logic [15:0] io_evt_set = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_e;
  logic        irq, irq_e;
  logic [31:0] rd, rd_e;
  int          tests = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  card_irq_unit #(.STAT_W(32), .IO_W(16), .EXT_CARD_DETECT(1'b0)) uut (
    .clk(clk), .rst(rst), .evt_set(evt_set), .wp_level(wp_level),
    .busy_level(busy_level), .io_evt_set(io_evt_set), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq));

  card_irq_unit #(.STAT_W(32), .IO_W(16), .EXT_CARD_DETECT(1'b1)) uut_ext (
    .clk(clk), .rst(rst), .evt_set(evt_set), .wp_level(wp_level),
    .busy_level(busy_level), .io_evt_set(io_evt_set), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_e), .irq(irq_e));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    rd = rdata; rd_e = rdata_e;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic pulse_io(input logic [15:0] v);
    @(negedge clk); io_evt_set = v;
    @(negedge clk); io_evt_set = '0;
  endtask

  task automatic t_reset;
    rd_reg(2'd0); check("R1 status", rd, 32'h0);
    rd_reg(2'd2); check("R1 io status", rd, 32'h0);
    rd_reg(2'd3); check("R1 io mask", rd, 32'h0000FFFF);
    rd_reg(2'd1); check("R1 mask", rd, 32'hFFFFFFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R11: new address shows only after the next edge
    reg_addr = 2'd0;
    #1 check("R11 old data held", rdata, 32'hFFFFFFFF);
    @(negedge clk);
    check("R11 new data", rdata, 32'h0);
  endtask

  task automatic t_sticky;
    pulse(32'h4);
    repeat (3) @(negedge clk);
    rd_reg(2'd0); check("R2 sticky", rd, 32'h4);
    check("R5 masked quiet", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    wr(2'd1, ~32'h4);
    @(negedge clk); check("R5 unmask raises", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'hFFFFFFFF);
    @(negedge clk); check("R5 remask drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear;
    pulse(32'h20);
    wr(2'd1, ~32'h24);
    @(negedge clk); check("R10 two pending", {31'b0, irq}, 32'h1);
    wr(2'd0, ~32'h4);
    rd_reg(2'd0); check("R3 clear one keep other", rd, 32'h20);
    check("R10 still high", {31'b0, irq}, 32'h1);
    wr(2'd0, ~32'h20);
    @(negedge clk); check("R10 falls", {31'b0, irq}, 32'h0);
    rd_reg(2'd0); check("R3 all cleared", rd, 32'h0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    evt_set = 32'h44; reg_addr = 2'd0; reg_wdata = 32'h0; reg_wr = 1'b1;
    @(negedge clk);
    evt_set = '0; reg_wr = 1'b0;
    rd_reg(2'd0); check("R4 set wins", rd, 32'h44);
    check("R5 unmasked bit raises", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0);
    @(negedge clk); check("R10 cleared drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_level;
    wr(2'd1, 32'h0);
    @(negedge clk); wp_level = 1'b1; busy_level = 1'b1;
    rd_reg(2'd0); check("R7 levels seen", rd, 32'hC00);
    check("R6 levels quiet", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0);
    rd_reg(2'd0); check("R7 write ignored", rd, 32'hC00);
    pulse(32'h0010_0000);
    rd_reg(2'd0); check("R6 reserved reads 0", rd, 32'hC00);
    check("R6 reserved quiet", {31'b0, irq}, 32'h0);
    @(negedge clk); wp_level = 1'b0; busy_level = 1'b0;
    rd_reg(2'd0); check("R7 levels follow", rd, 32'h0);
    wr(2'd1, 32'hFFFFFFFF);
  endtask

  task automatic t_io;
    pulse_io(16'h9);
    rd_reg(2'd2); check("R8 io status", rd, 32'h9);
    check("R8 io masked", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'hFFF7);
    @(negedge clk); check("R8 non-capable io bit quiet", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'hFFF6);
    @(negedge clk); check("R8 io int raises", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'hFFFFFFFE);
    rd_reg(2'd2); check("R8 io clear", rd, 32'h8);
    check("R8 io drops", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'hFFFF);
  endtask

  task automatic t_ext;
    wr(2'd1, 32'h0);
    rd_reg(2'd1); check("R9 forced mask", rd_e, 32'h3);
    check("R9 plain mask", rd, 32'h0);
    pulse(32'h3);
    @(negedge clk);
    check("R9 card events quiet", {31'b0, irq_e}, 32'h0);
    check("R5 card events raise", {31'b0, irq}, 32'h1);
    rd_reg(2'd0); check("R9 status still latched", rd_e, 32'h3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_sticky;
    t_mask;
    t_clear;
    t_collide;
    t_level;
    t_io;
    t_ext;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule